// File: doc/BRIEF.md
# Prescaled 16-bit Overflow Timer on a Byte Register Bus

This block is a free-running 16-bit up-counter that a processor reaches through an 8-bit register bus. A three-bit rate field picks whether the counter is stopped, advances on every clock, or advances once per 8, 64, 256 or 1024 clocks. When the counter passes its all-ones value it returns to zero and latches an overflow flag. When the enable bit is set, that flag drives an interrupt request.

Because the bus is one byte wide, the 16-bit count is read and written through a single shared high-byte holding register. A write to the high-byte address fills only that holding register. The later low-byte write then loads both halves into the counter in one cycle. A read of the low byte copies the matching high byte into the holding register in the same cycle, so the following high-byte read returns a value that pairs with the low byte already read, even while the counter keeps running.

Each access completes in the cycle its strobe is high and is never stalled, so the bus has no back-pressure. Read data is combinational from the address. The interrupt request is a level output; the flag behind it is cleared by the acknowledge input or by software. The register map is: 0 = rate control (bits 2:0), 1 = count low byte, 2 = count high byte (the holding register), 3 = interrupt enable (bit 0), 4 = overflow flag (bit 0). Any other address reads 0, and writes to it are ignored.

Top module: `timer16_top`

## Requirements
- R1: After reset the counter, the holding register, the rate field, the enable bit and the flag are all 0, every register address reads 0, and irq is 0.
- R2: A write to address 2 stores the byte in the holding register only and leaves the counter value unchanged.
- R3: A write to address 1 loads {holding register, written byte} into the counter at that clock edge.
- R4: Address 1 reads the live low byte of the counter. A read strobe on address 1 copies the live high byte into the holding register at the same edge. Address 2 reads the holding register.
- R5: Rate code 1, 2, 3, 4 or 5 advances the counter once every 1, 8, 64, 256 or 1024 clocks. Codes 0, 6 and 7 hold the counter.
- R6: A write of a new rate code restarts the divider, so the first increment comes exactly N clocks after the write edge, where N is the division ratio.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (address 4, bit 0).
- R8: irq is high only while both the overflow flag and the enable bit (address 3, bit 0) are 1. The flag is still set when the enable bit is 0.
- R9: Writing 1 to address 4 bit 0, or pulsing irq_ack, clears the flag. Writing 0 there has no effect. A new overflow in the same cycle wins over a clear.
- R10: A low-byte write in the same cycle as an increment takes priority, and that increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (snapshot side effect on address 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong holding-register state shows at the next address-2 read, or as a wrong upper byte after the next low-byte write. Either way it appears within two bus accesses. A divider that fails to restart moves the first increment away from exactly N cycles after the rate write, which a low-byte read at cycle N-1 and again at cycle N exposes. A lost or duplicated wrap shows on irq within one cycle of the count passing 0xFFFF, and in the count read back right after.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CLO  = 3'd1,
    A_CHI  = 3'd2,
    A_IEN  = 3'd3,
    A_FLAG = 3'd4
  } reg_addr_e;

  // log2 of the division ratio for a running rate code
  function automatic logic [3:0] rate_shift(input logic [2:0] code);
    case (code)
      3'd1:    rate_shift = 4'd0;
      3'd2:    rate_shift = 4'd3;
      3'd3:    rate_shift = 4'd6;
      3'd4:    rate_shift = 4'd8;
      3'd5:    rate_shift = 4'd10;
      default: rate_shift = 4'd0;
    endcase
  endfunction

  function automatic logic rate_runs(input logic [2:0] code);
    rate_runs = (code >= 3'd1) && (code <= 3'd5);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate,
  input  logic       restart,
  output logic       tick
);
  import timer_pkg::*;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] last;
  logic [PRE_W:0]   span;
  logic             run;

  always_comb begin
    run  = rate_runs(rate);
    span = ({{PRE_W{1'b0}}, 1'b1} << rate_shift(rate)) - 1'b1;
    last = span[PRE_W-1:0];
    tick = run && (div_q == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 div_q <= '0;
    else if (restart || !run)   div_q <= '0;
    else if (tick)              div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  // a bus load overrides a tick in the same cycle
  assign ovf = tick && !load && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  input  logic              irq_ack,
  output logic [2:0]        rate_q,
  output logic              rate_restart,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [DATA_W-1:0] temp_q,
  output logic              ien_q,
  output logic              flag_q,
  output logic              irq
);
  import timer_pkg::*;

  localparam int HI_W = CNT_W - DATA_W;

  logic wr_ctrl, wr_lo, wr_hi, wr_ien, wr_flag, rd_lo, flag_clr;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_lo    = bus_wr && (bus_addr == A_CLO);
    wr_hi    = bus_wr && (bus_addr == A_CHI);
    wr_ien   = bus_wr && (bus_addr == A_IEN);
    wr_flag  = bus_wr && (bus_addr == A_FLAG);
    rd_lo    = bus_rd && !bus_wr && (bus_addr == A_CLO);
    flag_clr = (wr_flag && bus_wdata[0]) || irq_ack;
    rate_restart = wr_ctrl && (bus_wdata[2:0] != rate_q);
    load     = wr_lo;
    load_val = {temp_q[HI_W-1:0], bus_wdata};
    irq      = flag_q && ien_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[2:0] = rate_q;
      A_CLO:   bus_rdata = cnt[DATA_W-1:0];
      A_CHI:   bus_rdata = temp_q;
      A_IEN:   bus_rdata[0] = ien_q;
      A_FLAG:  bus_rdata[0] = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) rate_q <= bus_wdata[2:0];
      if (wr_ien)  ien_q  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      temp_q <= '0;
    else if (wr_hi)  temp_q <= bus_wdata;
    else if (rd_lo)  temp_q <= cnt[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (ovf)       flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/timer16_top.sv
module timer16_top #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q, load_val;
  logic [DATA_W-1:0] temp_q;
  logic [2:0]        rate_q;
  logic              rate_restart, tick, load, ovf, ien_q, flag_q;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_q), .ovf(ovf), .irq_ack(irq_ack), .rate_q(rate_q),
    .rate_restart(rate_restart), .load(load), .load_val(load_val),
    .temp_q(temp_q), .ien_q(ien_q), .flag_q(flag_q), .irq(irq)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .rate(rate_q),
    .restart(rate_restart), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(load_val), .cnt(cnt_q), .ovf(ovf)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              irq_ack,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] temp,
  input logic [2:0]        rate,
  input logic              tick,
  input logic              ovf,
  input logic              flag,
  input logic              ien
);
  // R2
  hi_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !tick) |=> $stable(cnt));

  // R3
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (cnt == $past({temp, bus_wdata})));

  // R4
  lo_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd1) |=> (temp == $past(cnt[CNT_W-1:DATA_W])));

  // R5
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate == 3'd0 || rate > 3'd5) && !(bus_wr && bus_addr == 3'd1)) |=> $stable(cnt));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0 && flag));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ien && !(bus_wr && bus_addr == 3'd3)) |=> irq);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ovf) |=> !flag);
endmodule

bind timer16_top tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .irq_ack(irq_ack),
  .cnt(cnt_q), .temp(temp_q), .rate(rate_q), .tick(tick), .ovf(ovf),
  .flag(flag_q), .ien(ien_q)
);

// File: tb/sim_timer16_top.sv
`timescale 1ns/1ps
module sim_timer16_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int nchk = 0, nerr = 0;

  localparam logic [2:0] CTRL = 3'd0, CLO = 3'd1, CHI = 3'd2, IEN = 3'd3, FLG = 3'd4;

  always #2 clk = ~clk;

  timer16_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(CLO, lo);
    rd(CHI, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", {8'h0, d}, 16'h0);
    end
    check("R1 reset irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_access;
    logic [7:0] d;
    logic [15:0] v;
    wr(CHI, 8'hAB); wr(CLO, 8'hCD);
    rd16(v);
    check("R3 16-bit load", v, 16'hABCD);
    wr(CHI, 8'h12); wr(CLO, 8'h34);
    wr(CHI, 8'h77);
    rd(CLO, d);
    check("R2 low after high write", {8'h0, d}, 16'h0034);
    rd(CHI, d);
    check("R2 counter high untouched", {8'h0, d}, 16'h0012);
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    wr(CTRL, 3'd0); wr(CHI, 8'h12); wr(CLO, 8'hFF);
    wr(CTRL, 3'd1);
    rd(CLO, d);
    check("R4 live low", {8'h0, d}, 16'h00FF);
    rd(CHI, d);
    check("R4 high snapshot", {8'h0, d}, 16'h0012);
    wr(CTRL, 3'd0);
  endtask

  task automatic t_rate(input logic [2:0] code, input int n);
    logic [7:0] d;
    wr(CTRL, 3'd0); wr(CHI, 8'h00); wr(CLO, 8'h00);
    wr(CTRL, code);
    repeat (n - 1) @(negedge clk);
    rd(CLO, d);
    check($sformatf("R6 no step before %0d", n), {8'h0, d}, 16'h0000);
    rd(CLO, d);
    check($sformatf("R5 step at %0d", n), {8'h0, d}, 16'h0001);
  endtask

  task automatic t_stopped(input logic [2:0] code);
    logic [15:0] v;
    wr(CTRL, 3'd0); wr(CHI, 8'h56); wr(CLO, 8'h78);
    wr(CTRL, code);
    repeat (40) @(negedge clk);
    rd16(v);
    check($sformatf("R5 code %0d holds", code), v, 16'h5678);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    logic [15:0] v;
    wr(CTRL, 3'd0); wr(IEN, 8'h01); wr(CHI, 8'hFF); wr(CLO, 8'hFE);
    wr(CTRL, 3'd1);
    check("R8 irq before wrap", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R8 irq at 0xFFFF", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R7 irq on wrap", {15'h0, irq}, 16'h1);
    wr(CTRL, 3'd0);
    rd16(v);
    check("R7 count after wrap", v, 16'h0001);
    rd(FLG, d);
    check("R7 flag set", {8'h0, d}, 16'h0001);
    wr(FLG, 8'h00);
    rd(FLG, d);
    check("R9 write 0 ignored", {8'h0, d}, 16'h0001);
    wr(FLG, 8'h01);
    rd(FLG, d);
    check("R9 write 1 clears", {8'h0, d}, 16'h0000);
    check("R9 irq low after clear", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_mask_ack;
    logic [7:0] d;
    wr(IEN, 8'h00); wr(CHI, 8'hFF); wr(CLO, 8'hFF);
    wr(CTRL, 3'd1);
    wr(CTRL, 3'd0);
    check("R8 masked irq", {15'h0, irq}, 16'h0);
    rd(FLG, d);
    check("R8 flag set while masked", {8'h0, d}, 16'h0001);
    wr(IEN, 8'h01);
    check("R8 irq once enabled", {15'h0, irq}, 16'h1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R9 ack drops irq", {15'h0, irq}, 16'h0);
    rd(FLG, d);
    check("R9 ack clears flag", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(CTRL, 3'd0); wr(CHI, 8'h40);
    wr(CTRL, 3'd1);
    wr(CLO, 8'h10);
    rd(CLO, d);
    check("R10 load beats tick", {8'h0, d}, 16'h0010);
    rd(CLO, d);
    check("R10 counting resumes", {8'h0, d}, 16'h0011);
    rd(CHI, d);
    check("R10 high byte", {8'h0, d}, 16'h0040);
    wr(CTRL, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_access();
    t_snapshot();
    t_rate(3'd1, 1);
    t_rate(3'd2, 8);
    t_rate(3'd3, 64);
    t_rate(3'd4, 256);
    t_rate(3'd5, 1024);
    t_stopped(3'd0);
    t_stopped(3'd6);
    t_stopped(3'd7);
    t_wrap();
    t_mask_ack();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule